// File: doc/BRIEF.md
# Video RAM Copy Engine

This block moves bytes from any readable address into the video RAM window (0x8000 to 0x9FFF) on behalf of a processor. Software loads a 16-bit source and a 16-bit destination through four byte-wide address registers, then writes a control byte that sets the transfer length and picks one of two modes. In the general mode the whole length is copied at once while the processor is held off. In the blank-paced mode the copy is split into 16-byte blocks, and each rising edge of the horizontal-blank input releases exactly one block.

Every byte takes one read cycle followed by one write cycle on a plain memory-style master port. That port has no back-pressure: the memory must return read data in the same cycle the read strobe is high. Arbitration with other masters and the video timing generator sit outside this block.

Top module: `vram_dma`

## Requirements
- R1: After reset the four address registers read 0x00, the control register reads 0xFF, and `busy`, `cpu_stall`, `bus_rd` and `bus_wr` are all low.
- R2: An accepted control write captures the source from address registers 0 (high byte) and 1 (low byte) with bits [3:0] cleared. It captures the destination from registers 2 (high) and 3 (low) as (value AND 0x1FF0) OR 0x8000. Bytes are read at consecutive source addresses, and each written byte equals the byte just read.
- R3: A control write whose captured source lies in 0x8000 to 0x9FFF is dropped. No bytes move, `busy` stays low, and the control register keeps its previous value.
- R4: Control bits [6:0] hold n, and a general transfer moves (n+1)*16 bytes. Each byte uses one cycle with `bus_rd` high followed by one cycle with `bus_wr` high. The two strobes are never high together.
- R5: `cpu_stall` is high in every bus cycle of a run and in the one write-back cycle after it. For a general run of N bytes it is high for exactly 2N+1 cycles.
- R6: When a run ends, the advanced source and destination are written back into address registers 0 to 3.
- R7: When a general run completes, the control register reads 0x80 OR n.
- R8: Control bit 7 set arms blank-paced mode and no byte moves until `hblank` rises. Each rising edge moves exactly one 16-byte block. Holding `hblank` high does not start a second block.
- R9: While blank-paced mode is armed the control register reads n, and it drops by one after each block. The block that finds it at 0 wraps it to 0xFF and leaves the mode. Later `hblank` edges then move nothing.
- R10: A general run starts only when neither the previous mode nor the newly written mode is blank-paced. A control write with bit 7 clear while blank-paced mode is armed disarms it, stores the written byte, and moves nothing.
- R11: The destination advances only within 0x8000 to 0x9FFF, so 0x9FFF is followed by 0x8000.
- R12: Control writes made while `cpu_stall` is high are ignored and do not change the run in progress.
- R13: `busy` is high while a run is in progress or blank-paced mode is armed, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 src high, 1 src low, 2 dst high, 3 dst low, 4 control |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register (0xFF for unused selects) |
| hblank | input | 1 | Horizontal-blank level; its rising edge paces blocks |
| bus_addr | output | 16 | Master address (source in read cycles, destination in write cycles) |
| bus_rd | output | 1 | Master read strobe |
| bus_wr | output | 1 | Master write strobe |
| bus_wdata | output | 8 | Master write data |
| bus_rdata | input | 8 | Master read data, valid in the cycle `bus_rd` is high |
| cpu_stall | output | 1 | Holds the processor off while bytes move |
| busy | output | 1 | Run in progress or blank-paced mode armed |

## Verification
The properties assume three things about the environment. Memory answers a read within the same cycle. The processor leaves the address registers alone while it is stalled. `hblank` rises only when no block is in flight. The stimulus meets all three. It waits for `busy` and `cpu_stall` to fall before loading new addresses. It holds each blank pulse far longer than one 16-byte block and then lowers it well before the next. It drives the read data from a combinational function of the bus address. The single deliberate breach of the stall rule is a control write during a run, which checks R12.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
  localparam int ADDR_W = 16;

  typedef enum logic [2:0] {
    SEL_SRC_HI = 3'd0,
    SEL_SRC_LO = 3'd1,
    SEL_DST_HI = 3'd2,
    SEL_DST_LO = 3'd3,
    SEL_CTRL   = 3'd4
  } vdma_sel_e;
endpackage

// File: rtl/vdma_regfile.sv
module vdma_regfile
  import vdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        sel,
  input  logic [7:0]        wdata,
  input  logic              wb_en,
  input  logic [ADDR_W-1:0] wb_src,
  input  logic [ADDR_W-1:0] wb_dst,
  output logic [ADDR_W-1:0] src_raw,
  output logic [ADDR_W-1:0] dst_raw
);
  localparam int NBYTES = 2 * ADDR_W / 8;

  logic [2*ADDR_W-1:0] wb_all;
  logic [7:0]          bytes_q [NBYTES];

  assign wb_all = {wb_src, wb_dst};

  // byte i is the i-th byte counted from the top of {src, dst}
  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bytes_q[i] <= 8'h00;
      end else if (wb_en) begin
        bytes_q[i] <= wb_all[2*ADDR_W-1-8*i -: 8];
      end else if (wr_en && sel == 3'(i)) begin
        bytes_q[i] <= wdata;
      end
    end
  end

  assign src_raw = {bytes_q[0], bytes_q[1]};
  assign dst_raw = {bytes_q[2], bytes_q[3]};
endmodule

// File: rtl/vdma_mover.sv
module vdma_mover
  import vdma_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int WIN_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_src,
  input  logic [ADDR_W-1:0] load_dst,
  input  logic              go,
  input  logic [CNT_W-1:0]  go_len,
  input  logic [7:0]        bus_rdata,
  output logic              active,
  output logic              done,
  output logic [ADDR_W-1:0] cur_src,
  output logic [ADDR_W-1:0] cur_dst,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [7:0]        bus_wdata
);
  localparam logic [ADDR_W-1:0] WIN_MASK = ADDR_W'((1 << WIN_W) - 1);

  logic [ADDR_W-1:0] src_q, dst_q, dst_next;
  logic [CNT_W-1:0]  cnt_q;
  logic              act_q, wr_phase_q, done_q;
  logic [7:0]        data_q;

  // destination wraps inside the window, upper bits held
  assign dst_next = (dst_q & ~WIN_MASK) | ((dst_q + ADDR_W'(1)) & WIN_MASK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q      <= '0;
      dst_q      <= '0;
      cnt_q      <= '0;
      act_q      <= 1'b0;
      wr_phase_q <= 1'b0;
      done_q     <= 1'b0;
      data_q     <= 8'h00;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        src_q <= load_src;
        dst_q <= load_dst;
      end
      if (go) begin
        cnt_q      <= go_len;
        act_q      <= 1'b1;
        wr_phase_q <= 1'b0;
      end else if (act_q) begin
        if (!wr_phase_q) begin
          data_q     <= bus_rdata;
          wr_phase_q <= 1'b1;
        end else begin
          wr_phase_q <= 1'b0;
          src_q      <= src_q + ADDR_W'(1);
          dst_q      <= dst_next;
          cnt_q      <= cnt_q - CNT_W'(1);
          if (cnt_q == CNT_W'(1)) begin
            act_q  <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  assign active    = act_q;
  assign done      = done_q;
  assign cur_src   = src_q;
  assign cur_dst   = dst_q;
  assign bus_rd    = act_q & ~wr_phase_q;
  assign bus_wr    = act_q & wr_phase_q;
  assign bus_addr  = wr_phase_q ? dst_q : src_q;
  assign bus_wdata = data_q;
endmodule

// File: rtl/vram_dma.sv
module vram_dma
  import vdma_pkg::*;
#(
  parameter int                LEN_W     = 7,
  parameter int                BLK_LOG2  = 4,
  parameter int                WIN_W     = 13,
  parameter logic [ADDR_W-1:0] VRAM_BASE = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_sel,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              hblank,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [7:0]        bus_wdata,
  input  logic [7:0]        bus_rdata,
  output logic              cpu_stall,
  output logic              busy
);
  localparam int                CTRL_W   = LEN_W + 1;
  localparam int                CNT_W    = LEN_W + 1 + BLK_LOG2;
  localparam logic [ADDR_W-1:0] WIN_MASK = ADDR_W'((1 << WIN_W) - 1);
  localparam logic [ADDR_W-1:0] BLK_MASK = ~ADDR_W'((1 << BLK_LOG2) - 1);
  localparam logic [CNT_W-1:0]  BLK_LEN  = CNT_W'(1 << BLK_LOG2);

  logic [ADDR_W-1:0] src_raw, dst_raw, src_cap, dst_cap, cur_src, cur_dst;
  logic [CTRL_W-1:0] len_q;
  logic              hb_mode_q, hb_prev_q, run_hb_q;
  logic              active, done, ctrl_wr, src_bad, accept, gen_go, hb_go;
  logic              new_hb;
  logic [CNT_W-1:0]  go_len;

  assign src_cap = src_raw & BLK_MASK;
  assign dst_cap = (dst_raw & WIN_MASK & BLK_MASK) | VRAM_BASE;
  assign src_bad = (src_cap & ~WIN_MASK) == VRAM_BASE;
  assign new_hb  = reg_wdata[LEN_W];

  assign ctrl_wr = reg_wr && (reg_sel == SEL_CTRL) && !active && !done;
  assign accept  = ctrl_wr && !src_bad;
  assign gen_go  = accept && !hb_mode_q && !new_hb;
  assign hb_go   = hb_mode_q && hblank && !hb_prev_q && !active && !done && !accept;
  assign go_len  = gen_go ? (CNT_W'({1'b0, reg_wdata[LEN_W-1:0]} + CTRL_W'(1)) << BLK_LOG2)
                          : BLK_LEN;

  vdma_regfile u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr),
    .sel     (reg_sel),
    .wdata   (reg_wdata),
    .wb_en   (done),
    .wb_src  (cur_src),
    .wb_dst  (cur_dst),
    .src_raw (src_raw),
    .dst_raw (dst_raw)
  );

  vdma_mover #(.CNT_W(CNT_W), .WIN_W(WIN_W)) u_mover (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_src  (src_cap),
    .load_dst  (dst_cap),
    .go        (gen_go | hb_go),
    .go_len    (go_len),
    .bus_rdata (bus_rdata),
    .active    (active),
    .done      (done),
    .cur_src   (cur_src),
    .cur_dst   (cur_dst),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q     <= '1;
      hb_mode_q <= 1'b0;
      hb_prev_q <= 1'b0;
      run_hb_q  <= 1'b0;
    end else begin
      hb_prev_q <= hblank;
      if (gen_go || hb_go) run_hb_q <= hb_go;
      if (accept) begin
        hb_mode_q <= new_hb;
        len_q     <= new_hb ? {1'b0, reg_wdata[LEN_W-1:0]} : reg_wdata[CTRL_W-1:0];
      end else if (done) begin
        if (run_hb_q) begin
          len_q <= len_q - CTRL_W'(1);
          if (len_q == '0) hb_mode_q <= 1'b0;
        end else begin
          len_q[LEN_W] <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (vdma_sel_e'(reg_sel))
      SEL_SRC_HI: reg_rdata = src_raw[15:8];
      SEL_SRC_LO: reg_rdata = src_raw[7:0];
      SEL_DST_HI: reg_rdata = dst_raw[15:8];
      SEL_DST_LO: reg_rdata = dst_raw[7:0];
      SEL_CTRL:   reg_rdata = 8'(len_q);
      default:    reg_rdata = 8'hFF;
    endcase
  end

  assign cpu_stall = active | done;
  assign busy      = active | hb_mode_q;
endmodule

// File: rtl/vram_dma_checker.sv
module vram_dma_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] bus_addr,
  input logic        bus_rd,
  input logic        bus_wr,
  input logic        cpu_stall,
  input logic        busy
);
  assert_rw_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  assert_read_then_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_wr);

  assert_write_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> $past(bus_rd));

  assert_dst_in_window_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> (bus_addr[15:13] == 3'b100));

  assert_stall_covers_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |-> cpu_stall);

  assert_busy_covers_bus_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |-> busy);
endmodule

bind vram_dma vram_dma_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .cpu_stall (cpu_stall),
  .busy      (busy)
);

// File: tb/sim_vram_dma.sv
`timescale 1ns/1ps
module sim_vram_dma;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic        hblank = 1'b0;
  logic [15:0] bus_addr;
  logic        bus_rd, bus_wr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic        cpu_stall, busy;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  function automatic logic [15:0] dst_step(input logic [15:0] d, input int n);
    return 16'h8000 | ((d + 16'(n)) & 16'h1FFF);
  endfunction

  assign bus_rdata = memf(bus_addr);

  vram_dma u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hblank(hblank),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_stall(cpu_stall), .busy(busy)
  );

  // bus monitor, samples 2 ns after each rising edge
  logic        mon_clr = 1'b0;
  logic [15:0] mon_src0 = 16'h0, mon_dst0 = 16'h8000;
  logic [15:0] run_src, run_dst, last_rd;
  int wr_cnt, bad_cnt, stall_cnt;

  always @(posedge clk) begin
    #2;
    if (mon_clr) begin
      run_src = mon_src0; run_dst = mon_dst0;
      wr_cnt = 0; bad_cnt = 0; stall_cnt = 0;
    end else begin
      if (cpu_stall) stall_cnt++;
      if (bus_rd) begin
        if (bus_addr != run_src) bad_cnt++;
        last_rd = bus_addr;
        run_src = run_src + 16'd1;
      end
      if (bus_wr) begin
        if (bus_addr != run_dst || bus_wdata != memf(last_rd)) bad_cnt++;
        run_dst = dst_step(run_dst, 1);
        wr_cnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] s, output logic [7:0] d);
    @(negedge clk); reg_sel = s; #1 d = reg_rdata;
  endtask

  task automatic mon_start(input logic [15:0] s0, input logic [15:0] d0);
    @(negedge clk); mon_src0 = s0; mon_dst0 = d0; mon_clr = 1'b1;
    @(negedge clk); mon_clr = 1'b0;
  endtask

  task automatic set_addr(input logic [15:0] s, input logic [15:0] d);
    wr_reg(3'd0, s[15:8]); wr_reg(3'd1, s[7:0]);
    wr_reg(3'd2, d[15:8]); wr_reg(3'd3, d[7:0]);
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if (!busy && !cpu_stall) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic hb_pulse();
    @(negedge clk); hblank = 1'b1;
    repeat (50) @(negedge clk);
    hblank = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  // {source regs, destination regs, control byte}
  localparam logic [39:0] VEC [4] = '{
    {16'h1234, 16'h0567, 8'h00},
    {16'hC00F, 16'hFFFF, 8'h01},
    {16'h0000, 16'h8000, 8'h07},
    {16'hA0F0, 16'h1230, 8'h02}
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] r, r2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_reg(3'd0, r); chk(r == 8'h00, "R1 src hi", r, 0);
    rd_reg(3'd3, r); chk(r == 8'h00, "R1 dst lo", r, 0);
    rd_reg(3'd4, r); chk(r == 8'hFF, "R1 ctrl", r, 8'hFF);
    chk({busy, cpu_stall, bus_rd, bus_wr} == 4'b0, "R1 outputs",
        {busy, cpu_stall, bus_rd, bus_wr}, 0);

    // table of general transfers: R2 R4 R5 R6 R7 R11 R13
    for (int i = 0; i < 4; i++) begin
      logic [15:0] s, d, s0, d0, es, ed;
      logic [7:0]  c;
      int n;
      s = VEC[i][39:24]; d = VEC[i][23:8]; c = VEC[i][7:0];
      s0 = s & 16'hFFF0; d0 = (d & 16'h1FF0) | 16'h8000;
      n = (int'(c[6:0]) + 1) * 16;
      es = s0 + 16'(n); ed = dst_step(d0, n);
      set_addr(s, d);
      mon_start(s0, d0);
      wr_reg(3'd4, c);
      wait_idle();
      chk(wr_cnt == n, "R4 byte count", wr_cnt, n);
      chk(bad_cnt == 0, "R2 addresses and data", bad_cnt, 0);
      chk(stall_cnt == 2 * n + 1, "R5 stall cycles", stall_cnt, 2 * n + 1);
      rd_reg(3'd0, r); rd_reg(3'd1, r2);
      chk({r, r2} == es, "R6 source write-back", {r, r2}, es);
      rd_reg(3'd2, r); rd_reg(3'd3, r2);
      chk({r, r2} == ed, "R6 R11 destination write-back", {r, r2}, ed);
      rd_reg(3'd4, r);
      chk(r == (8'h80 | c), "R7 completion flag", r, 8'h80 | c);
      chk(busy == 1'b0, "R13 idle after run", busy, 0);
    end

    // R8 R9 R11 blank-paced mode
    set_addr(16'h1234, 16'h9FE5);
    mon_start(16'h1230, 16'h9FE0);
    wr_reg(3'd4, 8'h82);
    rd_reg(3'd4, r); chk(r == 8'h02, "R9 armed count", r, 2);
    chk(busy == 1'b1, "R13 busy while armed", busy, 1);
    repeat (10) @(negedge clk);
    chk(wr_cnt == 0, "R8 waits for hblank", wr_cnt, 0);
    hb_pulse();
    chk(wr_cnt == 16, "R8 one block per edge", wr_cnt, 16);
    rd_reg(3'd4, r); chk(r == 8'h01, "R9 decrement", r, 1);
    rd_reg(3'd0, r); rd_reg(3'd1, r2);
    chk({r, r2} == 16'h1240, "R6 block write-back", {r, r2}, 16'h1240);
    hb_pulse();
    rd_reg(3'd2, r); rd_reg(3'd3, r2);
    chk({r, r2} == 16'h8000, "R11 destination wrap", {r, r2}, 16'h8000);
    rd_reg(3'd4, r); chk(r == 8'h00, "R9 count zero", r, 0);
    hb_pulse();
    chk(wr_cnt == 48, "R9 last block", wr_cnt, 48);
    rd_reg(3'd4, r); chk(r == 8'hFF, "R9 wrap ends mode", r, 8'hFF);
    chk(busy == 1'b0, "R13 idle after last block", busy, 0);
    hb_pulse();
    chk(wr_cnt == 48, "R9 no block after end", wr_cnt, 48);
    chk(bad_cnt == 0, "R2 blank-paced data", bad_cnt, 0);

    // R10 disarm then general start
    set_addr(16'h0100, 16'h8000);
    mon_start(16'h0100, 16'h8000);
    wr_reg(3'd4, 8'h81);
    wr_reg(3'd4, 8'h05);
    repeat (20) @(negedge clk);
    chk(wr_cnt == 0, "R10 disarm moves nothing", wr_cnt, 0);
    chk(busy == 1'b0, "R10 disarmed", busy, 0);
    rd_reg(3'd4, r); chk(r == 8'h05, "R10 stored byte", r, 5);
    wr_reg(3'd4, 8'h00);
    wait_idle();
    chk(wr_cnt == 16, "R10 general after disarm", wr_cnt, 16);

    // R3 rejected sources, both ends of the window
    set_addr(16'h8800, 16'h8000);
    mon_start(16'h8800, 16'h8000);
    wr_reg(3'd4, 8'h03);
    repeat (20) @(negedge clk);
    chk(wr_cnt == 0, "R3 reject low", wr_cnt, 0);
    chk(busy == 1'b0, "R3 not busy", busy, 0);
    rd_reg(3'd4, r); chk(r == 8'h80, "R3 control unchanged", r, 8'h80);
    wr_reg(3'd0, 8'h9F); wr_reg(3'd1, 8'hFF);
    wr_reg(3'd4, 8'h81);
    repeat (20) @(negedge clk);
    chk(wr_cnt == 0 && !busy, "R3 reject high", wr_cnt, 0);

    // R12 control write during a run is ignored
    set_addr(16'h2000, 16'h8100);
    mon_start(16'h2000, 16'h8100);
    wr_reg(3'd4, 8'h03);
    repeat (10) @(negedge clk);
    wr_reg(3'd4, 8'h00);
    wait_idle();
    chk(wr_cnt == 64, "R12 length kept", wr_cnt, 64);
    rd_reg(3'd4, r); chk(r == 8'h83, "R12 control kept", r, 8'h83);
    chk(bad_cnt == 0, "R12 data", bad_cnt, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule